// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

One DMA channel that runs a transfer described by an eight-word, 32-byte control descriptor held in memory. The descriptor sets two nested loops. An inner (minor) loop moves a fixed number of bytes in elements of 1, 2, 4, 16 or 32 bytes. An outer (major) loop repeats the minor loop a programmed number of times. Source and destination addresses advance by their own signed offsets after each element. At the end of the major loop, each address takes its own adjustment. Instead of the destination adjustment, the descriptor may name a next descriptor, which the channel fetches and may start at once.

Software loads a descriptor by pulsing `desc_load` with its address. After that, each trigger runs one minor loop. A trigger is either a software start pulse or the hardware request line while the request enable is set. All data and descriptor traffic uses a single read/write master port with a request/acknowledge handshake. Data moves in beats of at most four bytes, right-aligned on the data bus. The channel reports completion through `done`, `active` and a one-cycle `irq`. A bad descriptor gives a one-cycle `err` and a cause code, and the channel drops the descriptor.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset `done`, `active`, `irq`, `err`, `hreq_en` and `mem_req` are all low and no descriptor is loaded.
- R2: A `desc_load` pulse makes the channel read eight 32-bit words at `desc_addr`, `desc_addr+4` … `desc_addr+28`. Word 0 is the source address, word 2 the minor byte count, word 3 the source end adjustment, word 4 the destination address and word 6 the destination end adjustment or next-descriptor address. If bit 0 (start) of word 7 is set, the first minor loop begins without a trigger.
- R3: Word 1 holds the source size code in bits 26:24, the destination size code in bits 18:16 and the signed source offset in bits 15:0. Word 5 holds the signed destination offset in bits 15:0. Size codes are 0, 1, 2, 4 and 5, for 1, 2, 4, 16 and 32 bytes.
- R4: A minor loop moves the minor byte count in elements of the size. An element of 4 bytes or more moves as 4-byte beats at the element address plus 4·k. Smaller elements move as one beat (`mem_size` 0/1/2 = 1/2/4 bytes, little-endian, low bytes of the bus). After each element the source adds its signed offset and the destination adds its own; an offset of 0 keeps a fixed address.
- R5: The current count is bits 30:16 of word 5, a 15-bit value. If bit 31 of word 5 is set, only bits 24:16 count. The beginning count is read from word 7 with the same layout. Each trigger runs one minor loop and decrements the count. Triggers are ignored while no descriptor is loaded.
- R6: A trigger is a `sw_start` pulse, or `hw_req` high while `hreq_en` is set. `hreq_en_set` sets `hreq_en`. `hw_req` has no effect while `hreq_en` is low.
- R7: When the count runs out (major completion), the source adds its end adjustment, the destination adds word 6 (unless bit 4 of word 7 is set), the count reloads from the beginning count and `done` rises. `done` clears when a minor loop starts or a descriptor load begins.
- R8: With bit 4 of word 7 set, major completion fetches the next descriptor from the address in word 6 and treats it as in R2.
- R9: `irq` pulses for one cycle at major completion when bit 1 of word 7 is set. It also pulses when the count reaches half the beginning count (integer halving, not at completion) when bit 2 is set.
- R10: When bit 3 of word 7 is set, major completion clears `hreq_en`.
- R11: After a fetch, the descriptor is checked, and on the first failing check `err` pulses with `err_code`. The checks, in order: code 1 for an unsupported size code; 2 for differing source and destination sizes; 3 for a zero minor count or one not a multiple of the size; 4 for a current count different from the beginning count; 5 for a source address, then 6 for a destination address, not aligned to the size. No data moves and the channel is left unloaded.
- R12: `mem_req` stays high with a stable address, size and direction until `mem_ack` is sampled high.
- R13: `active` is high exactly while a minor loop moves data; every data write happens while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Pulse: fetch a descriptor from `desc_addr` |
| desc_addr | input | 32 | Descriptor address for `desc_load` |
| sw_start | input | 1 | Pulse: software trigger of one minor loop |
| hw_req | input | 1 | Hardware request line |
| hreq_en_set | input | 1 | Pulse: set the hardware request enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Beat width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current beat |
| active | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop completed |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 1 | One-cycle configuration error pulse |
| err_code | output | 3 | Cause of the last error |
| hreq_en | output | 1 | Hardware request enable state |

## Verification
The hardest state to reach is a count wider than nine bits. Here the current count takes its upper bits from the link field, and the half-way interrupt, the completion interrupt and the request-enable drop all come from one long run. The bench gets there by loading a descriptor whose count is 512, with only the link field non-zero, and holding `hw_req` high so that 512 minor loops run back to back. It then counts the rising edges of `active` and the interrupt pulses, and checks that `hreq_en` fell and that no further minor loop starts. A slow-acknowledge memory mode stretches every handshake so the request-hold rule is exercised on fetch, read and write beats alike.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int CNT_W      = 15;
  localparam int BEAT_W     = 3;
  localparam int EB_W       = 6;

  typedef enum logic [2:0] {
    CFG_OK     = 3'd0,
    CFG_SIZE   = 3'd1,
    CFG_SZMIX  = 3'd2,
    CFG_NBYTES = 3'd3,
    CFG_ITER   = 3'd4,
    CFG_SALIGN = 3'd5,
    CFG_DALIGN = 3'd6
  } cfg_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHK, ST_RD, ST_WR
  } chan_st_e;

  function automatic logic size_ok(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic [EB_W-1:0] size_bytes(input logic [2:0] c);
    case (c)
      3'd1:    return 6'd2;
      3'd2:    return 6'd4;
      3'd4:    return 6'd16;
      3'd5:    return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] iter_of(input logic [WORD_W-1:0] w);
    return w[31] ? {6'd0, w[24:16]} : w[30:16];
  endfunction

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_chan_pkg::*;
(
  input  logic [WORD_W-1:0] src_w,
  input  logic [WORD_W-1:0] attr_w,
  input  logic [WORD_W-1:0] nbytes_w,
  input  logic [WORD_W-1:0] dst_w,
  input  logic [WORD_W-1:0] cur_w,
  input  logic [WORD_W-1:0] beg_w,
  output cfg_err_e          code
);
  logic [2:0]        ssz, dsz;
  logic [WORD_W-1:0] mask;

  assign ssz  = attr_w[26:24];
  assign dsz  = attr_w[18:16];
  assign mask = {{(WORD_W-EB_W){1'b0}}, size_bytes(ssz)} - 1'b1;

  always_comb begin
    if (!size_ok(ssz) || !size_ok(dsz))                     code = CFG_SIZE;
    else if (ssz != dsz)                                    code = CFG_SZMIX;
    else if (nbytes_w == '0 || (nbytes_w & mask) != '0)    code = CFG_NBYTES;
    else if (iter_of(cur_w) != iter_of(beg_w))              code = CFG_ITER;
    else if ((src_w & mask) != '0)                          code = CFG_SALIGN;
    else if ((dst_w & mask) != '0)                          code = CFG_DALIGN;
    else                                                    code = CFG_OK;
  end
endmodule

// File: rtl/dma_iter_ctr.sv
module dma_iter_ctr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] begin_val,
  input  logic         step,
  output logic         major_end,
  output logic         half_hit
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;

  assign nxt       = cnt - 1'b1;
  assign major_end = step && (cnt <= {{(W-1){1'b0}}, 1'b1});
  assign half_hit  = step && !major_end && (nxt == (begin_val >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (major_end)  cnt <= begin_val;
    else if (step)       cnt <= nxt;
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        desc_load,
  input  logic [31:0] desc_addr,
  input  logic        sw_start,
  input  logic        hw_req,
  input  logic        hreq_en_set,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        active,
  output logic        done,
  output logic        irq,
  output logic        err,
  output logic [2:0]  err_code,
  output logic        hreq_en
);
  chan_st_e          st;
  logic [WORD_W-1:0] dw [DESC_WORDS];
  logic [WIDX_W-1:0] widx;
  logic [WORD_W-1:0] fetch_ptr, saddr, daddr, left, rbuf;
  logic [BEAT_W-1:0] bidx;
  logic              loaded, done_q, irq_q, err_q, hreq_en_q;
  logic [2:0]        err_code_q;

  // decoded descriptor fields
  logic [EB_W-1:0]   ebytes;
  logic [3:0]        nbeats;
  logic [1:0]        bsize;
  logic [WORD_W-1:0] soff, doff, slast, dlast, nbytes;
  logic              ctl_esg, ctl_dreq, ctl_half, ctl_maj, ctl_start;

  assign ebytes    = size_bytes(dw[1][26:24]);
  assign nbeats    = (ebytes >= 6'd4) ? ebytes[5:2] : 4'd1;
  assign bsize     = (ebytes >= 6'd4) ? 2'd2 : ((ebytes == 6'd2) ? 2'd1 : 2'd0);
  assign soff      = sext16(dw[1][15:0]);
  assign doff      = sext16(dw[5][15:0]);
  assign nbytes    = dw[2];
  assign slast     = dw[3];
  assign dlast     = dw[6];
  assign ctl_esg   = dw[7][4];
  assign ctl_dreq  = dw[7][3];
  assign ctl_half  = dw[7][2];
  assign ctl_maj   = dw[7][1];
  assign ctl_start = dw[7][0];

  // named internal events
  logic     trig, elem_last, minor_last, minor_end, major_end, half_hit, chk_load;
  cfg_err_e cfg_code;

  assign trig       = sw_start || (hw_req && hreq_en_q);
  assign elem_last  = ({1'b0, bidx} == (nbeats - 4'd1));
  assign minor_last = elem_last && (left == {{(WORD_W-EB_W){1'b0}}, ebytes});
  assign minor_end  = (st == ST_WR) && mem_ack && minor_last;
  assign chk_load   = (st == ST_CHK) && (cfg_code == CFG_OK);

  dma_cfg_check u_chk (
    .src_w(dw[0]), .attr_w(dw[1]), .nbytes_w(dw[2]), .dst_w(dw[4]),
    .cur_w(dw[5]), .beg_w(dw[7]), .code(cfg_code)
  );

  dma_iter_ctr #(.W(CNT_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(chk_load),
    .load_val(iter_of(dw[5])), .begin_val(iter_of(dw[7])),
    .step(minor_end), .major_end(major_end), .half_hit(half_hit)
  );

  // memory port
  logic [WORD_W-1:0] beat_off;
  assign beat_off  = {{(WORD_W-BEAT_W-2){1'b0}}, bidx, 2'b00};
  assign mem_req   = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_size  = (st == ST_FETCH) ? 2'd2 : bsize;
  assign mem_wdata = rbuf;
  always_comb begin
    case (st)
      ST_FETCH: mem_addr = fetch_ptr + {{(WORD_W-WIDX_W-2){1'b0}}, widx, 2'b00};
      ST_RD:    mem_addr = saddr + beat_off;
      ST_WR:    mem_addr = daddr + beat_off;
      default:  mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; widx <= '0; fetch_ptr <= '0; saddr <= '0; daddr <= '0;
      left <= '0; rbuf <= '0; bidx <= '0; loaded <= 1'b0; done_q <= 1'b0;
      err_code_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (desc_load) begin
            fetch_ptr <= desc_addr; widx <= '0; loaded <= 1'b0;
            done_q <= 1'b0; st <= ST_FETCH;
          end else if (trig && loaded) begin
            done_q <= 1'b0; left <= nbytes; bidx <= '0; st <= ST_RD;
          end
        end
        ST_FETCH: if (mem_ack) begin
          dw[widx] <= mem_rdata;
          if (widx == WIDX_W'(DESC_WORDS - 1)) st <= ST_CHK;
          else widx <= widx + 1'b1;
        end
        ST_CHK: begin
          if (cfg_code != CFG_OK) begin
            err_code_q <= cfg_code; loaded <= 1'b0; st <= ST_IDLE;
          end else begin
            loaded <= 1'b1; saddr <= dw[0]; daddr <= dw[4];
            if (ctl_start) begin
              done_q <= 1'b0; left <= nbytes; bidx <= '0; st <= ST_RD;
            end else st <= ST_IDLE;
          end
        end
        ST_RD: if (mem_ack) begin
          rbuf <= mem_rdata; st <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          if (!elem_last) begin
            bidx <= bidx + 1'b1; st <= ST_RD;
          end else begin
            bidx <= '0;
            left <= left - {{(WORD_W-EB_W){1'b0}}, ebytes};
            if (!minor_last) begin
              saddr <= saddr + soff; daddr <= daddr + doff; st <= ST_RD;
            end else if (major_end) begin
              done_q <= 1'b1;
              saddr  <= saddr + soff + slast;
              if (ctl_esg) begin
                fetch_ptr <= dlast; widx <= '0; loaded <= 1'b0; st <= ST_FETCH;
              end else begin
                daddr <= daddr + doff + dlast; st <= ST_IDLE;
              end
            end else begin
              saddr <= saddr + soff; daddr <= daddr + doff; st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // pulses and request enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0; err_q <= 1'b0; hreq_en_q <= 1'b0;
    end else begin
      irq_q <= (major_end && ctl_maj) || (half_hit && ctl_half);
      err_q <= (st == ST_CHK) && (cfg_code != CFG_OK);
      if (major_end && ctl_dreq) hreq_en_q <= 1'b0;
      else if (hreq_en_set)      hreq_en_q <= 1'b1;
    end
  end

  assign active   = (st == ST_RD) || (st == ST_WR);
  assign done     = done_q;
  assign irq      = irq_q;
  assign err      = err_q;
  assign err_code = err_code_q;
  assign hreq_en  = hreq_en_q;
endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic        active,
  input logic        done,
  input logic        irq,
  input logic        err,
  input logic        hreq_en,
  input logic        minor_end,
  input logic        major_end,
  input logic        ctl_dreq
);
  AST_DONE_AFTER_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
    major_end |=> done); // R7
  AST_ERR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!active && !mem_req)); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size))); // R12
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_WRITE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> active); // R13
  AST_MINOR_END_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    minor_end |-> active); // R13
  AST_DREQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (major_end && ctl_dreq) |=> !hreq_en); // R10
endmodule

bind dma_chan_engine dma_chan_sva u_sva (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_size(mem_size), .active(active), .done(done), .irq(irq),
  .err(err), .hreq_en(hreq_en), .minor_end(minor_end), .major_end(major_end),
  .ctl_dreq(ctl_dreq)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        desc_load = 1'b0, sw_start = 1'b0, hw_req = 1'b0, hreq_en_set = 1'b0;
  logic [31:0] desc_addr = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        active, done, irq, err, hreq_en;
  logic [2:0]  err_code;

  always #2 clk = ~clk; // 250 MHz

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_addr(desc_addr),
    .sw_start(sw_start), .hw_req(hw_req), .hreq_en_set(hreq_en_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .active(active), .done(done), .irq(irq), .err(err), .err_code(err_code),
    .hreq_en(hreq_en)
  );

  int total = 0, failed = 0, act_rises = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model: sole writer of mem ----------------
  logic [7:0] mem [0:4095];
  int         wq_a[$];
  logic [7:0] wq_d[$];
  bit         filled = 1'b0, slow = 1'b0, tog = 1'b0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    if (!filled) begin
      for (int i = 0; i < 4096; i++) mem[i] = pat(i);
      filled = 1'b1;
    end
    while (wq_a.size() > 0) mem[wq_a.pop_front() & 4095] = wq_d.pop_front();
    tog = ~tog;
    mem_ack = mem_req && (!slow || tog);
    if (mem_ack) begin
      int a, n;
      a = int'(mem_addr) & 4095;
      n = (mem_size == 2'd0) ? 1 : ((mem_size == 2'd1) ? 2 : 4);
      mem_rdata = {mem[(a+3)&4095], mem[(a+2)&4095], mem[(a+1)&4095], mem[a]};
      if (mem_we) for (int k = 0; k < n; k++) mem[(a+k)&4095] = mem_wdata[8*k +: 8];
    end
  end

  // ---------------- scoreboard: expected events ----------------
  int evq[$]; // 100 = irq, 1..6 = err code

  task automatic expect_ev(input int v);
    evq.push_back(v);
  endtask

  logic act_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (active && !act_prev) act_rises++;
      act_prev = active;
      if (irq) begin
        if (evq.size() == 0) chk(1'b0, "R9 unexpected irq", 100, 0);
        else begin int e; e = evq.pop_front(); chk(e == 100, "R9 irq event", 100, e); end
      end
      if (err) begin
        if (evq.size() == 0) chk(1'b0, "R11 unexpected err", int'(err_code), 0);
        else begin int e; e = evq.pop_front(); chk(int'(err_code) == e, "R11 err code", int'(err_code), e); end
      end
    end
  end

  // ---------------- driver helpers ----------------
  task automatic put_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin wq_a.push_back(a + k); wq_d.push_back(w[8*k +: 8]); end
  endtask

  task automatic put_desc(input int base, input int s, input logic [2:0] ssz, input logic [2:0] dsz,
                          input logic [15:0] soff, input int nb, input int slast, input int d,
                          input logic [15:0] c_hi, input logic [15:0] doff, input int dlast,
                          input logic [15:0] b_hi, input logic [4:0] ctl);
    put_word(base + 0,  32'(s));
    put_word(base + 4,  {5'd0, ssz, 5'd0, dsz, soff});
    put_word(base + 8,  32'(nb));
    put_word(base + 12, 32'(slast));
    put_word(base + 16, 32'(d));
    put_word(base + 20, {c_hi, doff});
    put_word(base + 24, 32'(dlast));
    put_word(base + 28, {b_hi, 11'd0, ctl});
  endtask

  task automatic do_load(input int a);
    @(negedge clk); desc_load = 1'b1; desc_addr = 32'(a);
    @(negedge clk); desc_load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic wquiet();
    int q = 0;
    while (q < 8) begin @(negedge clk); if (mem_req) q = 0; else q++; end
  endtask

  function automatic bit copied(input int d, input int s, input int n);
    for (int i = 0; i < n; i++) if (mem[d+i] != pat(s+i)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit untouched(input int d, input int n);
    for (int i = 0; i < n; i++) if (mem[d+i] != pat(d+i)) return 1'b0;
    return 1'b1;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !active && !irq && !err && !hreq_en && !mem_req, "R1 reset state",
        {done, active, irq, err, hreq_en, mem_req}, 0);

    // R2 R3 R4 R5 R7 R9: 4-byte elements, two minor loops per major
    put_desc(32'h000, 32'h100, 3'd2, 3'd2, 16'd4, 16, -32, 32'h200,
             16'd2, 16'd4, 32'h20, 16'd2, 5'b00011);
    do_load(32'h000); wquiet();
    chk(copied(32'h200, 32'h100, 16) && untouched(32'h210, 16), "R2 start bit runs first minor", 0, 1);
    chk(done == 1'b0, "R7 done low mid-major", done, 0);
    expect_ev(100);
    do_start(); wquiet();
    chk(copied(32'h210, 32'h110, 16), "R4 second minor data", 0, 1);
    chk(done == 1'b1, "R7 done at major completion", done, 1);
    do_start(); wquiet();
    chk(copied(32'h240, 32'h100, 16), "R7 end adjustments applied", 0, 1);
    chk(done == 1'b0, "R7 done cleared by new minor", done, 0);

    // R4 fixed destination with byte elements
    put_desc(32'h040, 32'h300, 3'd0, 3'd0, 16'd1, 4, 0, 32'h400,
             16'd1, 16'd0, 0, 16'd1, 5'b00001);
    do_load(32'h040); wquiet();
    chk(mem[32'h400] == pat(32'h303) && untouched(32'h401, 3), "R4 zero dest offset", int'(mem[32'h400]), int'(pat(32'h303)));

    // R3 R4 32-byte element in 4-byte beats
    put_desc(32'h040, 32'h340, 3'd5, 3'd5, 16'd32, 32, 0, 32'h440,
             16'd1, 16'd32, 0, 16'd1, 5'b00001);
    do_load(32'h040); wquiet();
    chk(copied(32'h440, 32'h340, 32) && untouched(32'h460, 4), "R3 32-byte element copy", 0, 1);

    // R4 negative source offset, 2-byte elements
    put_desc(32'h040, 32'h51E, 3'd1, 3'd1, 16'hFFFE, 4, 0, 32'h600,
             16'd1, 16'd2, 0, 16'd1, 5'b00001);
    do_load(32'h040); wquiet();
    chk(copied(32'h600, 32'h51E, 2) && copied(32'h602, 32'h51C, 2), "R4 negative offset", int'(mem[32'h602]), int'(pat(32'h51C)));

    // R11 configuration errors
    put_desc(32'h060, 32'h100, 3'd3, 3'd3, 16'd4, 4, 0, 32'h700, 16'd1, 16'd4, 0, 16'd1, 5'b00001);
    expect_ev(1); do_load(32'h060); wquiet();
    put_desc(32'h060, 32'h100, 3'd2, 3'd0, 16'd4, 4, 0, 32'h700, 16'd1, 16'd4, 0, 16'd1, 5'b00001);
    expect_ev(2); do_load(32'h060); wquiet();
    put_desc(32'h060, 32'h100, 3'd2, 3'd2, 16'd4, 0, 0, 32'h700, 16'd1, 16'd4, 0, 16'd1, 5'b00001);
    expect_ev(3); do_load(32'h060); wquiet();
    put_desc(32'h060, 32'h100, 3'd2, 3'd2, 16'd4, 4, 0, 32'h700, 16'd3, 16'd4, 0, 16'd2, 5'b00001);
    expect_ev(4); do_load(32'h060); wquiet();
    put_desc(32'h060, 32'h102, 3'd2, 3'd2, 16'd4, 4, 0, 32'h700, 16'd1, 16'd4, 0, 16'd1, 5'b00001);
    expect_ev(5); do_load(32'h060); wquiet();
    put_desc(32'h060, 32'h100, 3'd2, 3'd2, 16'd4, 4, 0, 32'h702, 16'd1, 16'd4, 0, 16'd1, 5'b00001);
    expect_ev(6); do_load(32'h060); wquiet();
    r0 = act_rises;
    do_start(); wquiet();
    chk(act_rises == r0 && untouched(32'h700, 8), "R11 errored descriptor moves nothing", act_rises - r0, 0);
    chk(evq.size() == 0, "R11 all error events seen", evq.size(), 0);

    // R5 R6 R9 R10: 512 iterations carried in the link field, hardware requests
    put_desc(32'h0C0, 32'h800, 3'd0, 3'd0, 16'd0, 1, 0, 32'h900,
             16'h0200, 16'd0, 0, 16'h0200, 5'b01110);
    do_load(32'h0C0); wquiet();
    r0 = act_rises;
    hw_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(act_rises == r0, "R6 hw_req ignored without enable", act_rises - r0, 0);
    expect_ev(100); expect_ev(100);
    @(negedge clk); hreq_en_set = 1'b1;
    @(negedge clk); hreq_en_set = 1'b0;
    chk(hreq_en == 1'b1, "R6 enable set", hreq_en, 1);
    while (hreq_en) @(negedge clk);
    wquiet();
    chk(act_rises - r0 == 512, "R5 15-bit iteration count", act_rises - r0, 512);
    chk(done == 1'b1 && mem[32'h900] == pat(32'h800), "R7 done after long major", done, 1);
    chk(evq.size() == 0, "R9 half and major interrupts", evq.size(), 0);
    repeat (20) @(negedge clk);
    chk(act_rises - r0 == 512 && hreq_en == 1'b0, "R10 enable dropped stops requests", act_rises - r0, 512);
    hw_req = 1'b0;

    // R5 link-enabled count: only the 9 low bits count
    put_desc(32'h0C0, 32'h800, 3'd0, 3'd0, 16'd0, 1, 0, 32'h901,
             16'h8A03, 16'd0, 0, 16'h8A03, 5'b00010);
    do_load(32'h0C0); wquiet();
    r0 = act_rises;
    do_start(); wquiet();
    do_start(); wquiet();
    chk(done == 1'b0, "R5 9-bit count not yet complete", done, 0);
    expect_ev(100);
    do_start(); wquiet();
    chk(done == 1'b1 && act_rises - r0 == 3, "R5 9-bit count of three", act_rises - r0, 3);

    // R8 scatter/gather chain
    put_desc(32'h140, 32'hA00, 3'd2, 3'd2, 16'd4, 8, 0, 32'hB00,
             16'd1, 16'd4, 32'h180, 16'd1, 5'b10001);
    put_desc(32'h180, 32'hA40, 3'd2, 3'd2, 16'd4, 8, 0, 32'hB40,
             16'd1, 16'd4, 0, 16'd1, 5'b00011);
    expect_ev(100);
    do_load(32'h140); wquiet();
    chk(copied(32'hB00, 32'hA00, 8), "R8 first descriptor data", 0, 1);
    chk(copied(32'hB40, 32'hA40, 8) && done == 1'b1, "R8 chained descriptor ran", done, 1);

    // R12 slow acknowledge
    slow = 1'b1;
    put_desc(32'h1C0, 32'hA80, 3'd4, 3'd4, 16'd16, 16, 0, 32'hC00,
             16'd1, 16'd16, 0, 16'd1, 5'b00001);
    do_load(32'h1C0); wquiet();
    chk(copied(32'hC00, 32'hA80, 16) && untouched(32'hC10, 4), "R12 copy under stalled acks", 0, 1);
    slow = 1'b0;

    repeat (4) @(negedge clk);
    chk(evq.size() == 0, "R9 scoreboard drained", evq.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule